// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the pending-interrupt flags and the interrupt enables of a small peripheral that has seven interrupt sources: two timers, four handshake control lines and a serial shifter. Each source raises its flag with a one-cycle set request, whether or not it is enabled. Other parts of the peripheral lower flags through a clear request vector. The CPU sees two byte-wide registers. One shows the flags and the other shows the enables. Writes to the flag register clear the bits written as one. Writes to the enable register either set or clear the bits written as one, and bit 7 of the written byte picks which.

The interrupt request output is a level. It is high while at least one flag is set whose enable is also set. Any access to the shifter's data register clears the shifter flag as a side effect. That access is decoded here so the shifter needs no clear wire of its own. When a set request and any kind of clear reach the same bit in one cycle, the set takes effect.

Top module: `irq_flag_ctrl`

## Requirements
- R1: Flag bit positions are fixed: bit 6 timer one, bit 5 timer two, bit 4 control line B1, bit 3 control line B2, bit 2 shifter, bit 1 control line A1, bit 0 control line A2. A pulse on `set_req[i]` sets flag bit i, and flag bit i reads back at data bit i at offset 0xD.
- R2: A set request sets its flag whether or not the matching enable is set.
- R3: A write at offset 0xD clears every flag bit whose data bit is 1. Flag bits written as 0 keep their value.
- R4: A write at offset 0xE with data bit 7 = 1 sets every enable bit whose data bit is 1. The other enable bits keep their value.
- R5: A write at offset 0xE with data bit 7 = 0 clears every enable bit whose data bit is 1. The other enable bits keep their value.
- R6: A read at offset 0xE returns the enables in bits 6:0, and bit 7 always reads as 1.
- R7: A read at offset 0xD returns 1 in bit 7 when any flag is set together with its enable, and 0 otherwise.
- R8: `irq` equals the OR over all bits of (flag AND enable). It drops in the cycle after the last such flag is cleared.
- R9: If a set request and a clear (register write, `clr_req` or shifter access) hit the same flag bit in one cycle, the flag ends up set.
- R10: A read or a write at offset 0xA clears flag bit 2.
- R11: A pulse on `clr_req[i]` clears flag bit i.
- R12: Reset clears all flags and all enables. After reset, offset 0xD reads 0x00, offset 0xE reads 0x80 and `irq` is low.
- R13: A read at any other offset, or any cycle without `rd_en`, returns 0x00. A write at any offset other than 0xD, 0xE or 0xA changes no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| set_req | input | 7 | Per-source flag set pulses |
| clr_req | input | 7 | Per-bit flag clear pulses from other register accesses |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They place no limit on set and clear requests, which may land on any bit, at any time, together with a register access. The random stimulus draws read, write or idle as one exclusive choice per cycle, so both strobes never appear together. It draws set and clear vectors as free random bytes. It picks offsets mostly from 0xA, 0xD and 0xE, so that collisions between sets and every clear path happen often.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int SRC_N = 7;
    localparam int REG_W = SRC_N + 1;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef enum int {
        SRC_LINE_A2  = 0,
        SRC_LINE_A1  = 1,
        SRC_SHIFTER  = 2,
        SRC_LINE_B2  = 3,
        SRC_LINE_B1  = 4,
        SRC_TIMER_2  = 5,
        SRC_TIMER_1  = 6
    } src_pos_e;

    typedef struct packed {
        src_vec_t flags;
        src_vec_t enables;
    } irqc_state_t;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode #(
    parameter int          ADDR_W    = 4,
    parameter logic [3:0]  FLAG_OFS  = 4'hD,
    parameter logic [3:0]  ENA_OFS   = 4'hE,
    parameter logic [3:0]  SHIFT_OFS = 4'hA
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              flag_wr,
    output logic              flag_rd,
    output logic              ena_wr,
    output logic              ena_rd,
    output logic              shift_touch
);
    localparam logic [ADDR_W-1:0] FLAG_A  = ADDR_W'(FLAG_OFS);
    localparam logic [ADDR_W-1:0] ENA_A   = ADDR_W'(ENA_OFS);
    localparam logic [ADDR_W-1:0] SHIFT_A = ADDR_W'(SHIFT_OFS);

    always_comb begin
        flag_wr     = wr_en && (addr == FLAG_A);
        flag_rd     = rd_en && (addr == FLAG_A);
        ena_wr      = wr_en && (addr == ENA_A);
        ena_rd      = rd_en && (addr == ENA_A);
        shift_touch = (wr_en || rd_en) && (addr == SHIFT_A);
    end
endmodule

// File: rtl/irqc_flag_next.sv
module irqc_flag_next
    import irqc_pkg::*;
#(
    parameter int SHIFT_BIT = SRC_SHIFTER
) (
    input  src_vec_t cur,
    input  src_vec_t set_req,
    input  src_vec_t clr_req,
    input  logic     flag_wr,
    input  src_vec_t wbits,
    input  logic     shift_touch,
    output src_vec_t nxt
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        logic kill;
        always_comb begin
            kill = clr_req[i] || (flag_wr && wbits[i]);
            if (i == SHIFT_BIT) begin
                kill = kill || shift_touch;
            end
            nxt[i] = set_req[i] || (cur[i] && !kill);
        end
    end
endmodule

// File: rtl/irqc_enable_next.sv
module irqc_enable_next
    import irqc_pkg::*;
(
    input  src_vec_t cur,
    input  logic     ena_wr,
    input  logic     set_mode,
    input  src_vec_t wbits,
    output src_vec_t nxt
);
    for (genvar i = 0; i < SRC_N; i++) begin : g_bit
        always_comb begin
            if (ena_wr && wbits[i]) begin
                nxt[i] = set_mode;
            end else begin
                nxt[i] = cur[i];
            end
        end
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int         ADDR_W    = 4,
    parameter logic [3:0] FLAG_OFS  = 4'hD,
    parameter logic [3:0] ENA_OFS   = 4'hE,
    parameter logic [3:0] SHIFT_OFS = 4'hA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [SRC_N-1:0]  set_req,
    input  logic [SRC_N-1:0]  clr_req,
    output logic              irq
);
    localparam int MODE_BIT = REG_W - 1;

    irqc_state_t st_d, st_q;
    logic        flag_wr, flag_rd, ena_wr, ena_rd, shift_touch;
    src_vec_t    flag_nxt, ena_nxt, flag_q, ena_q, live;

    irqc_decode #(
        .ADDR_W   (ADDR_W),
        .FLAG_OFS (FLAG_OFS),
        .ENA_OFS  (ENA_OFS),
        .SHIFT_OFS(SHIFT_OFS)
    ) u_dec (
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .flag_wr    (flag_wr),
        .flag_rd    (flag_rd),
        .ena_wr     (ena_wr),
        .ena_rd     (ena_rd),
        .shift_touch(shift_touch)
    );

    irqc_flag_next #(.SHIFT_BIT(SRC_SHIFTER)) u_flag (
        .cur        (st_q.flags),
        .set_req    (set_req),
        .clr_req    (clr_req),
        .flag_wr    (flag_wr),
        .wbits      (wdata[SRC_N-1:0]),
        .shift_touch(shift_touch),
        .nxt        (flag_nxt)
    );

    irqc_enable_next u_ena (
        .cur     (st_q.enables),
        .ena_wr  (ena_wr),
        .set_mode(wdata[MODE_BIT]),
        .wbits   (wdata[SRC_N-1:0]),
        .nxt     (ena_nxt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.flags   = flag_nxt;
        st_d.enables = ena_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flags;
    assign ena_q  = st_q.enables;
    assign live   = st_q.flags & st_q.enables;
    assign irq    = |live;

    always_comb begin
        rdata = '0;
        if (flag_rd) begin
            rdata = {(|live), st_q.flags};
        end else if (ena_rd) begin
            rdata = {1'b1, st_q.enables};
        end
    end
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks
    import irqc_pkg::*;
#(
    parameter int         ADDR_W    = 4,
    parameter logic [3:0] FLAG_OFS  = 4'hD,
    parameter logic [3:0] ENA_OFS   = 4'hE,
    parameter logic [3:0] SHIFT_OFS = 4'hA
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [REG_W-1:0]  wdata,
    input logic [REG_W-1:0]  rdata,
    input logic [SRC_N-1:0]  set_req,
    input logic [SRC_N-1:0]  clr_req,
    input logic              irq,
    input logic [SRC_N-1:0]  flag_q,
    input logic [SRC_N-1:0]  ena_q
);
    localparam logic [ADDR_W-1:0] FA = ADDR_W'(FLAG_OFS);
    localparam logic [ADDR_W-1:0] EA = ADDR_W'(ENA_OFS);
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(SHIFT_OFS);

    AST_SET_REACHES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_req) |=> ((flag_q & $past(set_req)) == $past(set_req))); // R9
    AST_NO_UNREQUESTED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(set_req)) == '0)); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == FA) |=> ((flag_q & $past(wdata[SRC_N-1:0] & ~set_req)) == '0)); // R3
    AST_ENA_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == EA && wdata[REG_W-1]) |=>
        ((ena_q & $past(wdata[SRC_N-1:0])) == $past(wdata[SRC_N-1:0]))); // R4
    AST_ENA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == EA && !wdata[REG_W-1]) |=>
        ((ena_q & $past(wdata[SRC_N-1:0])) == '0)); // R5
    AST_ENA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == EA) |=> $stable(ena_q)); // R13
    AST_ENA_READ_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == EA) |-> rdata[REG_W-1]); // R6
    AST_FLAG_READ_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == FA) |-> (rdata[REG_W-1] == irq)); // R7
    AST_SHIFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && addr == SA) |=>
        (!flag_q[SRC_SHIFTER] || $past(set_req[SRC_SHIFTER]))); // R10
    AST_CLR_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_req) |=> ((flag_q & $past(clr_req & ~set_req)) == '0)); // R11
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !irq); // R8
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_q == '0 && ena_q == '0 && !irq)); // R12
endmodule

bind irq_flag_ctrl irqc_checks #(
    .ADDR_W   (ADDR_W),
    .FLAG_OFS (FLAG_OFS),
    .ENA_OFS  (ENA_OFS),
    .SHIFT_OFS(SHIFT_OFS)
) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .addr   (addr),
    .wdata  (wdata),
    .rdata  (rdata),
    .set_req(set_req),
    .clr_req(clr_req),
    .irq    (irq),
    .flag_q (flag_q),
    .ena_q  (ena_q)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [6:0] set_req = 7'h00;
    logic [6:0] clr_req = 7'h00;
    logic       irq;

    int nvec = 0;
    int nerr = 0;
    logic [6:0] m_flag = 7'h00;
    logic [6:0] m_ena  = 7'h00;
    logic [7:0] last_rd;
    logic       last_irq;

    always #10 clk = ~clk;

    irq_flag_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .set_req(set_req), .clr_req(clr_req), .irq(irq)
    );

    function automatic logic [7:0] exp_rdata(logic rd, logic [3:0] a, logic [6:0] f, logic [6:0] e);
        if (!rd) return 8'h00;
        if (a == 4'hD) return {|(f & e), f};
        if (a == 4'hE) return {1'b1, e};
        return 8'h00;
    endfunction

    function automatic logic [6:0] next_flag(logic [6:0] f, logic wr, logic rd, logic [3:0] a,
                                             logic [7:0] d, logic [6:0] s, logic [6:0] c);
        logic [6:0] k;
        k = c;
        if (wr && a == 4'hD) k = k | d[6:0];
        if ((wr || rd) && a == 4'hA) k = k | 7'h04;
        return (f & ~k) | s;
    endfunction

    function automatic logic [6:0] next_ena(logic [6:0] e, logic wr, logic [3:0] a, logic [7:0] d);
        if (wr && a == 4'hE) return d[7] ? (e | d[6:0]) : (e & ~d[6:0]);
        return e;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(string tag, logic wr, logic rd, logic [3:0] a, logic [7:0] d,
                        logic [6:0] s, logic [6:0] c);
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = a; wdata = d; set_req = s; clr_req = c;
        #5;
        last_rd  = rdata;
        last_irq = irq;
        chk({tag, " rdata"}, rdata, exp_rdata(rd, a, m_flag, m_ena));
        chk("R8 irq", {7'h0, irq}, {7'h0, |(m_flag & m_ena)});
        @(posedge clk);
        m_flag = next_flag(m_flag, wr, rd, a, d, s, c);
        m_ena  = next_ena(m_ena, wr, a, d);
    endtask

    task automatic idle();
        step("R13", 1'b0, 1'b0, 4'h0, 8'h00, 7'h00, 7'h00);
    endtask

    task automatic rd(string tag, logic [3:0] a);
        step(tag, 1'b0, 1'b1, a, 8'h00, 7'h00, 7'h00);
    endtask

    task automatic wr(string tag, logic [3:0] a, logic [7:0] d);
        step(tag, 1'b1, 1'b0, a, d, 7'h00, 7'h00);
    endtask

    initial begin
        #(200000 * 20);
        nerr++;
        $display("FAIL R12 watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C3A));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd("R12", 4'hD); chk("R12 flags", last_rd, 8'h00);
        rd("R12", 4'hE); chk("R12 enables", last_rd, 8'h80);
        chk("R12 irq", {7'h0, last_irq}, 8'h00);

        // R1, R2 each source lands on its own bit with enables off
        for (int i = 0; i < 7; i++) begin
            step("R1", 1'b0, 1'b0, 4'h0, 8'h00, 7'(1 << i), 7'h00);
            rd("R1", 4'hD); chk("R1 bit position", last_rd, 8'(1 << i));
            chk("R2 no irq while disabled", {7'h0, last_irq}, 8'h00);
            wr("R3", 4'hD, 8'h7F);
        end

        // R3 partial write-one-to-clear
        step("R3", 1'b0, 1'b0, 4'h0, 8'h00, 7'h55, 7'h00);
        wr("R3", 4'hD, 8'h05);
        rd("R3", 4'hD); chk("R3 partial clear", last_rd, 8'h50);

        // R4, R5 enable set and clear modes
        wr("R4", 4'hE, 8'hC1);
        rd("R4", 4'hE); chk("R4 set mode", last_rd, 8'hC1);
        wr("R5", 4'hE, 8'h01);
        rd("R5", 4'hE); chk("R5 clear mode", last_rd, 8'hC0);
        wr("R5", 4'hE, 8'h00);
        rd("R6", 4'hE); chk("R6 zero write keeps", last_rd, 8'hC0);

        // R7, R8 flag 6 enabled
        step("R8", 1'b0, 1'b0, 4'h0, 8'h00, 7'h40, 7'h00);
        rd("R7", 4'hD); chk("R7 summary bit", last_rd, 8'hD0);
        chk("R8 irq high", {7'h0, last_irq}, 8'h01);
        wr("R8", 4'hD, 8'h40);
        idle(); chk("R8 irq dropped", {7'h0, last_irq}, 8'h00);
        rd("R7", 4'hD); chk("R7 summary clear", last_rd, 8'h10);

        // R9 set beats every clear path
        step("R9", 1'b1, 1'b0, 4'hD, 8'h7F, 7'h01, 7'h00);
        step("R9", 1'b0, 1'b0, 4'h0, 8'h00, 7'h02, 7'h02);
        rd("R9", 4'hD); chk("R9 set wins", last_rd, 8'h03);

        // R10 shifter data access clears bit 2
        step("R10", 1'b0, 1'b0, 4'h0, 8'h00, 7'h04, 7'h00);
        rd("R10", 4'hA);
        rd("R10", 4'hD); chk("R10 read clears", last_rd, 8'h03);
        step("R10", 1'b0, 1'b0, 4'h0, 8'h00, 7'h04, 7'h00);
        wr("R10", 4'hA, 8'h00);
        rd("R10", 4'hD); chk("R10 write clears", last_rd, 8'h03);
        step("R10", 1'b0, 1'b1, 4'hA, 8'h00, 7'h04, 7'h00);
        rd("R10", 4'hD); chk("R10 set wins", last_rd, 8'h07);

        // R11 clear request vector
        step("R11", 1'b0, 1'b0, 4'h0, 8'h00, 7'h00, 7'h05);
        rd("R11", 4'hD); chk("R11 clear", last_rd, 8'h02);

        // R13 other offsets
        wr("R13", 4'h5, 8'hFF);
        rd("R13", 4'h5); chk("R13 other read", last_rd, 8'h00);
        rd("R13", 4'hD); chk("R13 flags kept", last_rd, 8'h02);
        rd("R13", 4'hE); chk("R13 enables kept", last_rd, 8'hC0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int op;
            int sel;
            logic [3:0] a;
            logic [6:0] s;
            logic [6:0] c;
            op  = int'($urandom_range(0, 2));
            sel = int'($urandom_range(0, 9));
            a   = (sel < 3) ? 4'hD : (sel < 6) ? 4'hE : (sel < 8) ? 4'hA : 4'($urandom);
            s   = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h00;
            c   = ($urandom_range(0, 3) == 0) ? 7'($urandom) : 7'h00;
            step((a == 4'hE) ? "R6" : (a == 4'hD) ? "R7" : "R13",
                 op == 1, op == 2, a, 8'($urandom), s, c);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule